// File: doc/BRIEF.md
# Serial NOR flash identification and bring-up sequencer

After a start pulse this block drives a byte-wide SPI master handshake to find out which serial NOR flash is attached and to leave it ready for writing. It runs an identification frame, checks the vendor and family bytes that come back, and turns the capacity byte into one of four geometry profiles: sector count, page count and address width. Parts that need wide addressing get an extra frame that switches them to 4-byte addressing. Every accepted part then gets a write-enable frame, followed by a status-write frame that clears all protection bits.

The byte shifter sits outside the block. The block asks for one byte at a time with a one-cycle request pulse and waits for the shifter's completion pulse, which carries the byte received. The block owns the chip-select line and releases it between frames. When the run ends, a one-cycle done pulse is raised, together with a held ok or error flag and registered geometry values. A failed run leaves the geometry at zero.

Top module: `flash_id_init`

## Requirements
- R1: Out of reset, chip select is high (deselected), no byte request is pending, done, ok and err are low, and sectors, pages and addr_bytes are zero.
- R2: A start pulse opens one chip-select frame that sends 0x9F and then three bytes of 0xA5. The 2nd, 3rd and 4th bytes received are taken as vendor, family and capacity, in that order.
- R3: The part is accepted only when the vendor byte is 0x9D and the family byte is 0x60. Otherwise err is set and no further frame is sent.
- R4: Capacity 0x17, 0x18, 0x19 and 0x1A give 2048, 4096, 8192 and 16384 sectors, and 32768, 65536, 131072 and 262144 pages respectively.
- R5: addr_bytes reports 3 for capacity 0x17 and 0x18, and 4 for 0x19 and 0x1A.
- R6: Only when addr_bytes is 4, a one-byte frame carrying 0xB7 follows the identification frame.
- R7: Every accepted part then receives a one-byte frame 0x06, followed by a two-byte frame 0x01, 0x00. These are the last frames of the run.
- R8: Chip select goes high between frames. A byte request is raised only while chip select is low, and no new request is made until the previous byte has completed.
- R9: A capacity byte outside 0x17 to 0x1A, with a valid vendor and family, sets err, keeps the geometry outputs at zero and sends no further frame.
- R10: done pulses for exactly one cycle at the end of a run. ok and err never hold together, stay held after done, and both clear in the cycle after the next accepted start.
- R11: A start pulse while a run is in progress is ignored. The run completes with a single done pulse and the normal frame sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Pulse that begins a bring-up run |
| done | output | 1 | One-cycle pulse when the run ends |
| ok | output | 1 | Run succeeded, held until next start |
| err | output | 1 | Run failed, held until next start |
| sectors | output | 15 | Decoded sector count (4096-byte sectors) |
| pages | output | 19 | Decoded page count (256-byte pages) |
| addr_bytes | output | 3 | Address width in bytes (3 or 4), zero when unknown |
| cs_n | output | 1 | Flash chip select, active low |
| byte_req | output | 1 | One-cycle request to shift byte_tx |
| byte_tx | output | 8 | Byte to send |
| byte_done | input | 1 | Shifter completion pulse |
| byte_rx | input | 8 | Byte received with byte_done |

## Verification
The hardest case to reach from the ports is a second start that lands in the middle of a run, while the frame engine is waiting on the shifter. The bench reaches it by pulsing start again a few cycles after the first pulse, while its shifter model is still holding back a completion. It then checks that there is still only one done pulse and the normal frame list. Bad vendor, family and capacity codes come from the shifter model's reply bytes. The bench logs each chip-select frame it sees, so a missing or extra command frame shows up as a byte-by-byte mismatch.

// File: rtl/fid_pkg.sv
package fid_pkg;

    localparam int FRAME_MAX = 4;

    localparam logic [7:0] OP_IDENT  = 8'h9F;
    localparam logic [7:0] OP_FILL   = 8'hA5;
    localparam logic [7:0] OP_WIDE   = 8'hB7;
    localparam logic [7:0] OP_WEN    = 8'h06;
    localparam logic [7:0] OP_STATW  = 8'h01;
    localparam logic [7:0] STAT_OPEN = 8'h00;
    localparam logic [7:0] VENDOR_OK = 8'h9D;
    localparam logic [7:0] FAMILY_OK = 8'h60;

    typedef enum logic [2:0] {
        STEP_IDLE,
        STEP_IDENT,
        STEP_WIDE,
        STEP_WEN,
        STEP_STATW
    } step_e;

    typedef struct packed {
        logic [2:0]                     len;
        logic [FRAME_MAX-1:0][7:0]      bytes;
    } frame_t;

    // Bytes of the frame for each step; element 0 is sent first.
    function automatic frame_t frame_for(step_e s);
        frame_t f;
        f.len   = 3'd0;
        f.bytes = '0;
        case (s)
            STEP_IDENT: begin
                f.len      = 3'd4;
                f.bytes[0] = OP_IDENT;
                f.bytes[1] = OP_FILL;
                f.bytes[2] = OP_FILL;
                f.bytes[3] = OP_FILL;
            end
            STEP_WIDE: begin
                f.len      = 3'd1;
                f.bytes[0] = OP_WIDE;
            end
            STEP_WEN: begin
                f.len      = 3'd1;
                f.bytes[0] = OP_WEN;
            end
            STEP_STATW: begin
                f.len      = 3'd2;
                f.bytes[0] = OP_STATW;
                f.bytes[1] = STAT_OPEN;
            end
            default: ;
        endcase
        return f;
    endfunction

endpackage

// File: rtl/fid_geom.sv
module fid_geom #(
    parameter logic [7:0] BASE_CODE   = 8'h17,
    parameter int         NPROF       = 4,
    parameter int         BASE_SECT   = 2048,
    parameter int         PG_PER_SECT = 16,
    parameter int         WIDE_FROM   = 2,
    parameter int         SECT_W      = 15,
    parameter int         PAGE_W      = 19
) (
    input  logic [7:0]        cap_code,
    output logic              hit,
    output logic [SECT_W-1:0] sect,
    output logic [PAGE_W-1:0] page,
    output logic              wide
);
    localparam int PG_SH = $clog2(PG_PER_SECT);

    logic [NPROF-1:0]              match;
    logic [NPROF-1:0][SECT_W-1:0]  sect_v;
    logic [NPROF-1:0]              wide_v;

    for (genvar i = 0; i < NPROF; i++) begin : g_prof
        assign match[i]  = (cap_code == BASE_CODE + 8'(i));
        assign sect_v[i] = match[i] ? SECT_W'(BASE_SECT << i) : '0;
        assign wide_v[i] = match[i] && (i >= WIDE_FROM);
    end

    always_comb begin
        sect = '0;
        for (int k = 0; k < NPROF; k++) sect = sect | sect_v[k];
    end

    assign hit  = |match;
    assign wide = |wide_v;
    assign page = PAGE_W'(sect) << PG_SH;

endmodule

// File: rtl/fid_frame.sv
module fid_frame #(
    parameter int MAXB = 4,
    parameter int LW   = 3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 go,
    input  logic [LW-1:0]        len,
    input  logic [MAXB-1:0][7:0] tx_bytes,
    output logic                 byte_req,
    output logic [7:0]           byte_tx,
    input  logic                 byte_done,
    input  logic [7:0]           byte_rx,
    output logic                 cs_n,
    output logic                 frame_done,
    output logic [MAXB-1:0][7:0] rx_bytes
);
    localparam int IW = (MAXB > 1) ? $clog2(MAXB) : 1;

    typedef enum logic [1:0] {FE_IDLE, FE_SEND, FE_WAIT} fe_e;

    typedef struct packed {
        fe_e                  st;
        logic [IW-1:0]        idx;
        logic [LW-1:0]        len;
        logic [MAXB-1:0][7:0] txb;
        logic [MAXB-1:0][7:0] rxb;
        logic                 cs_n;
        logic                 fdone;
    } fe_t;

    fe_t fe_d, fe_q;

    always_comb begin
        fe_d       = fe_q;
        fe_d.fdone = 1'b0;
        case (fe_q.st)
            FE_IDLE: if (go) begin
                fe_d.txb  = tx_bytes;
                fe_d.len  = len;
                fe_d.idx  = '0;
                fe_d.rxb  = '0;
                fe_d.cs_n = 1'b0;
                fe_d.st   = FE_SEND;
            end
            FE_SEND: fe_d.st = FE_WAIT;
            FE_WAIT: if (byte_done) begin
                fe_d.rxb[fe_q.idx] = byte_rx;
                if (LW'(fe_q.idx) + LW'(1) >= fe_q.len) begin
                    fe_d.cs_n  = 1'b1;
                    fe_d.fdone = 1'b1;
                    fe_d.st    = FE_IDLE;
                end else begin
                    fe_d.idx = fe_q.idx + IW'(1);
                    fe_d.st  = FE_SEND;
                end
            end
            default: fe_d.st = FE_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fe_q      <= '0;
            fe_q.st   <= FE_IDLE;
            fe_q.cs_n <= 1'b1;
        end else begin
            fe_q <= fe_d;
        end
    end

    assign byte_req   = (fe_q.st == FE_SEND);
    assign byte_tx    = fe_q.txb[fe_q.idx];
    assign cs_n       = fe_q.cs_n;
    assign frame_done = fe_q.fdone;
    assign rx_bytes   = fe_q.rxb;

    // R8: bytes move only inside a selected frame
    p_req_selected_r8: assert property (@(posedge clk) disable iff (!rst_n)
        byte_req |-> !cs_n);
    // R8: one outstanding byte at a time
    p_req_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
        byte_req |=> !byte_req);
    // R8: frame end releases chip select
    p_end_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |-> cs_n);

endmodule

// File: rtl/flash_id_init.sv
module flash_id_init #(
    parameter int         NPROF       = 4,
    parameter int         BASE_SECT   = 2048,
    parameter int         PG_PER_SECT = 16,
    parameter logic [7:0] BASE_CODE   = 8'h17,
    parameter int         WIDE_FROM   = 2,
    parameter int         SECT_W      = $clog2(BASE_SECT) + NPROF,
    parameter int         PAGE_W      = SECT_W + $clog2(PG_PER_SECT)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    output logic              done,
    output logic              ok,
    output logic              err,
    output logic [SECT_W-1:0] sectors,
    output logic [PAGE_W-1:0] pages,
    output logic [2:0]        addr_bytes,
    output logic              cs_n,
    output logic              byte_req,
    output logic [7:0]        byte_tx,
    input  logic              byte_done,
    input  logic [7:0]        byte_rx
);
    import fid_pkg::*;

    typedef struct packed {
        step_e             step;
        logic              go;
        logic              done;
        logic              ok;
        logic              err;
        logic [SECT_W-1:0] sect;
        logic [PAGE_W-1:0] page;
        logic [2:0]        abytes;
    } ctl_t;

    ctl_t c_d, c_q;

    logic                      frame_done;
    logic [FRAME_MAX-1:0][7:0] rx_bytes;
    frame_t                    cur_frame;
    logic                      g_hit, g_wide;
    logic [SECT_W-1:0]         g_sect;
    logic [PAGE_W-1:0]         g_page;
    logic                      id_good;

    fid_geom #(
        .BASE_CODE(BASE_CODE), .NPROF(NPROF), .BASE_SECT(BASE_SECT),
        .PG_PER_SECT(PG_PER_SECT), .WIDE_FROM(WIDE_FROM),
        .SECT_W(SECT_W), .PAGE_W(PAGE_W)
    ) u_geom (
        .cap_code(rx_bytes[3]),
        .hit     (g_hit),
        .sect    (g_sect),
        .page    (g_page),
        .wide    (g_wide)
    );

    assign cur_frame = frame_for(c_q.step);

    fid_frame #(.MAXB(FRAME_MAX), .LW(3)) u_frame (
        .clk       (clk),
        .rst_n     (rst_n),
        .go        (c_q.go),
        .len       (cur_frame.len),
        .tx_bytes  (cur_frame.bytes),
        .byte_req  (byte_req),
        .byte_tx   (byte_tx),
        .byte_done (byte_done),
        .byte_rx   (byte_rx),
        .cs_n      (cs_n),
        .frame_done(frame_done),
        .rx_bytes  (rx_bytes)
    );

    assign id_good = (rx_bytes[1] == VENDOR_OK) && (rx_bytes[2] == FAMILY_OK) && g_hit;

    always_comb begin
        c_d      = c_q;
        c_d.go   = 1'b0;
        c_d.done = 1'b0;
        case (c_q.step)
            STEP_IDLE: if (start) begin
                c_d.ok     = 1'b0;
                c_d.err    = 1'b0;
                c_d.sect   = '0;
                c_d.page   = '0;
                c_d.abytes = '0;
                c_d.step   = STEP_IDENT;
                c_d.go     = 1'b1;
            end
            STEP_IDENT: if (frame_done) begin
                if (id_good) begin
                    c_d.sect   = g_sect;
                    c_d.page   = g_page;
                    c_d.abytes = g_wide ? 3'd4 : 3'd3;
                    c_d.step   = g_wide ? STEP_WIDE : STEP_WEN;
                    c_d.go     = 1'b1;
                end else begin
                    c_d.err  = 1'b1;
                    c_d.done = 1'b1;
                    c_d.step = STEP_IDLE;
                end
            end
            STEP_WIDE: if (frame_done) begin
                c_d.step = STEP_WEN;
                c_d.go   = 1'b1;
            end
            STEP_WEN: if (frame_done) begin
                c_d.step = STEP_STATW;
                c_d.go   = 1'b1;
            end
            STEP_STATW: if (frame_done) begin
                c_d.ok   = 1'b1;
                c_d.done = 1'b1;
                c_d.step = STEP_IDLE;
            end
            default: c_d.step = STEP_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            c_q      <= '0;
            c_q.step <= STEP_IDLE;
        end else begin
            c_q <= c_d;
        end
    end

    assign done       = c_q.done;
    assign ok         = c_q.ok;
    assign err        = c_q.err;
    assign sectors    = c_q.sect;
    assign pages      = c_q.page;
    assign addr_bytes = c_q.abytes;

    // R10: outcome flags are exclusive
    p_flags_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(ok && err));
    // R10: done lasts one cycle
    p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R9: failure leaves geometry cleared
    p_geom_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> (sectors == '0 && pages == '0 && addr_bytes == 3'd0));
    // R5: accepted parts report a legal address width
    p_addr_legal_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ok |-> (addr_bytes == 3'd3 || addr_bytes == 3'd4));
    // R8: a new frame never starts while one is selected
    p_go_deselected_r8: assert property (@(posedge clk) disable iff (!rst_n)
        c_q.go |-> cs_n);

endmodule

// File: tb/sim_flash_id_init.sv
module sim_flash_id_init;
    localparam int LAT = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        done, ok, err;
    logic [14:0] sectors;
    logic [18:0] pages;
    logic [2:0]  addr_bytes;
    logic        cs_n, byte_req;
    logic [7:0]  byte_tx;
    logic        byte_done = 1'b0;
    logic [7:0]  byte_rx = 8'h00;

    always #10 clk = ~clk;

    flash_id_init u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .done(done), .ok(ok), .err(err),
        .sectors(sectors), .pages(pages), .addr_bytes(addr_bytes), .cs_n(cs_n),
        .byte_req(byte_req), .byte_tx(byte_tx), .byte_done(byte_done), .byte_rx(byte_rx)
    );

    int total = 0;
    int bad = 0;
    bit finished = 0;

    // shifter + flash model
    logic [7:0]  id_v = 8'h9D, id_f = 8'h60, id_c = 8'h17;
    logic [31:0] fr_bytes [8];
    int          fr_len [8];
    logic [31:0] cur_bytes = '0;
    int          nfr = 0, fidx = 0, done_cnt = 0, req_bad = 0, cnt = 0;
    bit          pend = 0, prev_cs = 1;
    logic [7:0]  reply = 8'h00;

    always @(posedge clk) begin
        byte_done <= 1'b0;
        if (done) done_cnt++;
        if (byte_req) begin
            if (cs_n) req_bad++;
            if (fidx < 4) cur_bytes[fidx*8 +: 8] = byte_tx;
            case (fidx)
                1: reply = id_v;
                2: reply = id_f;
                3: reply = id_c;
                default: reply = 8'hFF;
            endcase
            fidx++;
            pend = 1;
            cnt  = LAT;
        end else if (pend) begin
            cnt--;
            if (cnt == 0) begin
                byte_done <= 1'b1;
                byte_rx   <= reply;
                pend = 0;
            end
        end
        if (cs_n && !prev_cs) begin
            if (nfr < 8) begin
                fr_bytes[nfr] = cur_bytes;
                fr_len[nfr]   = fidx;
            end
            nfr++;
            fidx = 0;
            cur_bytes = '0;
        end
        prev_cs = cs_n;
    end

    task automatic chk(input bit cond, input string req, input longint act, input longint exp);
        total++;
        if (!cond) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    int cyc = 0;
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
            finish_run();
        end
    end

    task automatic clear_log();
        nfr = 0;
        done_cnt = 0;
    endtask

    task automatic pulse_start();
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_done(output bit seen);
        seen = 0;
        for (int i = 0; i < 3000 && !seen; i++) begin
            @(negedge clk);
            if (done) seen = 1;
        end
    endtask

    // table: vendor, family, capacity, ok, sectors, pages, addr bytes, frames
    localparam logic [64:0] VEC [8] = '{
        {8'h9D, 8'h60, 8'h17, 1'b1, 15'd2048,  19'd32768,  3'd3, 3'd3},
        {8'h9D, 8'h60, 8'h18, 1'b1, 15'd4096,  19'd65536,  3'd3, 3'd3},
        {8'h9D, 8'h60, 8'h19, 1'b1, 15'd8192,  19'd131072, 3'd4, 3'd4},
        {8'h9D, 8'h60, 8'h1A, 1'b1, 15'd16384, 19'd262144, 3'd4, 3'd4},
        {8'h9C, 8'h60, 8'h17, 1'b0, 15'd0,     19'd0,      3'd0, 3'd1},
        {8'h9D, 8'h61, 8'h18, 1'b0, 15'd0,     19'd0,      3'd0, 3'd1},
        {8'h9D, 8'h60, 8'h16, 1'b0, 15'd0,     19'd0,      3'd0, 3'd1},
        {8'h9D, 8'h60, 8'h1B, 1'b0, 15'd0,     19'd0,      3'd0, 3'd1}
    };

    task automatic check_outcome(input logic [64:0] v);
        bit         e_ok   = v[40];
        logic [2:0] e_addr = v[5:3];
        int         e_nfr  = int'(v[2:0]);
        int         k;
        chk(ok == e_ok && err == !e_ok, e_ok ? "R3 ok flag" : "R3/R9 err flag", {ok, err}, {e_ok, !e_ok});
        chk(sectors == v[39:25], "R4/R9 sectors", sectors, v[39:25]);
        chk(pages == v[24:6], "R4/R9 pages", pages, v[24:6]);
        chk(addr_bytes == e_addr, "R5 addr_bytes", addr_bytes, e_addr);
        chk(nfr == e_nfr, "R3/R6/R7 frame count", nfr, e_nfr);
        chk(fr_len[0] == 4 && fr_bytes[0] == 32'hA5A5A59F, "R2 ident frame", fr_bytes[0], 32'hA5A5A59F);
        if (e_ok && nfr == e_nfr) begin
            k = 1;
            if (e_addr == 3'd4) begin
                chk(fr_len[1] == 1 && fr_bytes[1] == 32'hB7, "R6 wide frame", fr_bytes[1], 32'hB7);
                k = 2;
            end
            chk(fr_len[k] == 1 && fr_bytes[k] == 32'h06, "R7 write enable frame", fr_bytes[k], 32'h06);
            chk(fr_len[k+1] == 2 && fr_bytes[k+1] == 32'h01, "R7 status frame", fr_bytes[k+1], 32'h01);
        end
        chk(done_cnt == 1, "R10 single done", done_cnt, 1);
        chk(req_bad == 0, "R8 request outside frame", req_bad, 0);
    endtask

    initial begin
        bit seen;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(cs_n == 1'b1 && byte_req == 1'b0, "R1 bus idle", {cs_n, byte_req}, 2'b10);
        chk(!done && !ok && !err, "R1 flags", {done, ok, err}, 3'b000);
        chk(sectors == 0 && pages == 0 && addr_bytes == 0, "R1 geometry", {sectors, pages, addr_bytes}, 0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int i = 0; i < 8; i++) begin
            id_v = VEC[i][64:57];
            id_f = VEC[i][56:49];
            id_c = VEC[i][48:41];
            clear_log();
            pulse_start();
            wait_done(seen);
            chk(seen, "R10 done seen", seen, 1);
            repeat (20) @(negedge clk);
            check_outcome(VEC[i]);
        end

        // R10: flags held after done, cleared after next start
        chk(err == 1'b1 && done == 1'b0, "R10 err held", {err, done}, 2'b10);
        id_v = 8'h9D; id_f = 8'h60; id_c = 8'h19;
        clear_log();
        pulse_start();
        chk(!ok && !err, "R10 flags cleared by start", {ok, err}, 2'b00);

        // R11: second start mid-run is ignored
        repeat (4) @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        wait_done(seen);
        repeat (30) @(negedge clk);
        check_outcome({8'h9D, 8'h60, 8'h19, 1'b1, 15'd8192, 19'd131072, 3'd4, 3'd4});
        chk(ok == 1'b1 && !done, "R11 ok held after ignored start", {ok, done}, 2'b10);

        finish_run();
    end

endmodule